// File: doc/BRIEF.md
# Palette DAC Host Port

This block is the host-facing side of a colour lookup table. A processor reaches it through four byte-wide registers, chosen by a two-bit port select: a pixel mask, a read pointer, a write pointer and a data window. A palette entry holds three colour bytes, stored as red, green and blue. Software sets a pointer and then moves whole entries through the data window one byte at a time. After every third byte the pointer steps on to the next entry by itself.

Writes and reads through the data window share a single component counter. Loading either pointer clears that counter. On a write, the first two bytes wait in a staging register, and the full entry enters the palette only when the third byte arrives. On a read, the first byte copies the whole entry into a holding register, and the next two bytes come from that copy. A separate lookup port returns, with no clock delay, the palette entry at the pixel value ANDed with the mask register.

Top module: `pal_dac_port`

## Requirements
- R1: After reset the mask reads 0xFF, both pointers read 0, the component counter is 0, the holding register is zero, and every palette entry is zero.
- R2: Port select 0 is the mask, 1 is the read pointer and 2 is the write pointer. Each is 8 bits wide and reads back the last value written to it.
- R3: Port select 3 is the data window. Data writes fill red, green and blue in that order. On the third byte the entry is stored at the write pointer, and the write pointer then steps by one, wrapping from 255 to 0.
- R4: The first data read, at component 0, returns red straight from the entry at the read pointer and copies that entry into the holding register. The next two reads return green and then blue from the copy. After the third read the read pointer steps by one, wrapping from 255 to 0.
- R5: Writing the read pointer or the write pointer clears the component counter. Any entry left part-way is dropped and never stored.
- R6: lookup_o carries the entry at (pix_i AND mask) as {red, green, blue} in bits 23:16, 15:8 and 7:0, in the same cycle as pix_i.
- R7: When wr_en_i and rd_en_i are both high, only the write takes place. rdata_o reads zero whenever no read alone is taking place.
- R8: Reads of port selects 0 to 2 change no state.
- R9: The component counter is shared. A data access always uses the component left by the previous data access of either kind, and the counter counts 0, 1, 2 and then back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Port select: 0 mask, 1 read pointer, 2 write pointer, 3 data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid in the same cycle as the read strobe |
| pix_i | input | 8 | Pixel value for lookup |
| lookup_o | output | 24 | Masked palette entry {r,g,b} |

## Verification
If the component counter is wrong, the very next data read returns the wrong colour byte. A wrong counter also makes a pointer step early or late, and that shows at the next pointer read. A write that is stored too early, or stored at the wrong place, shows on lookup_o in the cycle after the bad clock edge, because the lookup is combinational. The bench compares both outputs with a behavioural model on every clock, so any divergence is reported within one cycle.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  parameter int unsigned CW = 8;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;
endpackage

// File: rtl/pal_dac_ctrl.sv
module pal_dac_ctrl
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [CW-1:0]    wdata_i,
  output logic [IDX_W-1:0] mask_o,
  output logic [IDX_W-1:0] ridx_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [1:0]       comp_o,
  output logic             commit_o,
  output rgb_t             commit_rgb_o,
  output logic             rd_first_o,
  output logic             rd_acc_o
);
  localparam logic [1:0] LAST = 2'd2;

  logic [IDX_W-1:0] mask_q, ridx_q, widx_q;
  logic [1:0]       comp_q;
  logic [CW-1:0]    stg_r_q, stg_g_q;
  logic             rd_acc, data_wr, data_rd, last;

  // write wins when both strobes are high
  assign rd_acc  = rd_en_i & ~wr_en_i;
  assign data_wr = wr_en_i & (port_e'(sel_i) == PORT_DATA);
  assign data_rd = rd_acc  & (port_e'(sel_i) == PORT_DATA);
  assign last    = (comp_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      ridx_q  <= '0;
      widx_q  <= '0;
      comp_q  <= '0;
      stg_r_q <= '0;
      stg_g_q <= '0;
    end else if (wr_en_i) begin
      unique case (port_e'(sel_i))
        PORT_MASK: mask_q <= wdata_i[IDX_W-1:0];
        PORT_RIDX: begin
          ridx_q <= wdata_i[IDX_W-1:0];
          comp_q <= '0;
        end
        PORT_WIDX: begin
          widx_q <= wdata_i[IDX_W-1:0];
          comp_q <= '0;
        end
        PORT_DATA: begin
          if (comp_q == 2'd0) stg_r_q <= wdata_i;
          if (comp_q == 2'd1) stg_g_q <= wdata_i;
          comp_q <= last ? 2'd0 : comp_q + 2'd1;
          if (last) widx_q <= widx_q + 1'b1;
        end
        default: ;
      endcase
    end else if (data_rd) begin
      comp_q <= last ? 2'd0 : comp_q + 2'd1;
      if (last) ridx_q <= ridx_q + 1'b1;
    end
  end

  assign mask_o       = mask_q;
  assign ridx_o       = ridx_q;
  assign widx_o       = widx_q;
  assign comp_o       = comp_q;
  assign commit_o     = data_wr & last;
  assign commit_rgb_o = '{r: stg_r_q, g: stg_g_q, b: wdata_i};
  assign rd_first_o   = data_rd & (comp_q == 2'd0);
  assign rd_acc_o     = rd_acc;
endmodule

// File: rtl/pal_dac_mem.sv
module pal_dac_mem
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  rgb_t             wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output rgb_t             rdata_o,
  input  logic [IDX_W-1:0] laddr_i,
  output rgb_t             ldata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  rgb_t ent_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[e] <= '0;
      else if (we_i && (waddr_i == IDX_W'(e)))       ent_q[e] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
  assign ldata_o = ent_q[laddr_i];
endmodule

// File: rtl/pal_dac_rdpath.sv
module pal_dac_rdpath
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             rd_acc_i,
  input  logic             rd_first_i,
  input  logic [1:0]       comp_i,
  input  rgb_t             entry_i,
  input  logic [IDX_W-1:0] mask_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic [IDX_W-1:0] widx_i,
  output logic [CW-1:0]    rdata_o
);
  rgb_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (rd_first_i) hold_q <= entry_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc_i) begin
      unique case (port_e'(sel_i))
        PORT_MASK: rdata_o = CW'(mask_i);
        PORT_RIDX: rdata_o = CW'(ridx_i);
        PORT_WIDX: rdata_o = CW'(widx_i);
        PORT_DATA: begin
          unique case (comp_i)
            2'd0:    rdata_o = entry_i.r;
            2'd1:    rdata_o = hold_q.g;
            default: rdata_o = hold_q.b;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      sel_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   rdata_o,
  input  logic [IDX_W-1:0] pix_i,
  output logic [3*CW-1:0] lookup_o
);
  logic [IDX_W-1:0] mask_w, ridx_w, widx_w;
  logic [1:0]       comp_w;
  logic             commit_w, rd_first_w, rd_acc_w;
  rgb_t             commit_rgb_w, rd_ent_w, lk_ent_w;

  pal_dac_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .sel_i, .wr_en_i, .rd_en_i, .wdata_i,
    .mask_o(mask_w), .ridx_o(ridx_w), .widx_o(widx_w), .comp_o(comp_w),
    .commit_o(commit_w), .commit_rgb_o(commit_rgb_w),
    .rd_first_o(rd_first_w), .rd_acc_o(rd_acc_w)
  );

  pal_dac_mem #(.IDX_W(IDX_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(commit_w), .waddr_i(widx_w), .wdata_i(commit_rgb_w),
    .raddr_i(ridx_w), .rdata_o(rd_ent_w),
    .laddr_i(pix_i & mask_w), .ldata_o(lk_ent_w)
  );

  pal_dac_rdpath #(.IDX_W(IDX_W)) u_rd (
    .clk_i, .rst_ni, .sel_i, .rd_acc_i(rd_acc_w), .rd_first_i(rd_first_w),
    .comp_i(comp_w), .entry_i(rd_ent_w),
    .mask_i(mask_w), .ridx_i(ridx_w), .widx_i(widx_w), .rdata_o
  );

  assign lookup_o = lk_ent_w;
endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [IDX_W-1:0] mask_i,
  input logic [IDX_W-1:0] ridx_i,
  input logic [IDX_W-1:0] widx_i,
  input logic [1:0]       comp_i
);
  AST_COMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_i != 2'd3); // R9

  AST_IDX_CLEARS_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (sel_i == 2'd1 || sel_i == 2'd2) |=> comp_i == 2'd0); // R5

  AST_WIDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sel_i == 2'd3 && comp_i == 2'd2
    |=> widx_i == IDX_W'($past(widx_i) + 1'b1)); // R3

  AST_RIDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && sel_i == 2'd3 && comp_i == 2'd2
    |=> ridx_i == IDX_W'($past(ridx_i) + 1'b1)); // R4

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i == 2'd0) |=> $stable(mask_i)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && rd_en_i && sel_i == 2'd3 |=> $stable(ridx_i)); // R7
endmodule

bind pal_dac_port pal_dac_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .mask_i(mask_w), .ridx_i(ridx_w), .widx_i(widx_w),
  .comp_i(comp_w)
);

// File: tb/pal_dac_port_tb_top.sv
`timescale 1ns/1ps
module pal_dac_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  wd = '0, pix = '0;
  logic [7:0]  rdata;
  logic [23:0] look;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference
  int pr[256], pg[256], pb[256];
  int m_mask, m_ridx, m_widx, m_cnt, h_r, h_g, h_b, s_r, s_g;

  always #10 clk = ~clk;

  pal_dac_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_en_i(we), .rd_en_i(re),
    .wdata_i(wd), .rdata_o(rdata), .pix_i(pix), .lookup_o(look)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int s);
    case (s)
      0: return m_mask;
      1: return m_ridx;
      2: return m_widx;
      default: return (m_cnt == 0) ? pr[m_ridx] : (m_cnt == 1) ? h_g : h_b;
    endcase
  endfunction

  task automatic model_step(int s, bit w, bit r, int d);
    if (w) begin
      case (s)
        0: m_mask = d;
        1: begin m_ridx = d; m_cnt = 0; end
        2: begin m_widx = d; m_cnt = 0; end
        default: begin
          if (m_cnt == 0) s_r = d;
          else if (m_cnt == 1) s_g = d;
          else begin
            pr[m_widx] = s_r; pg[m_widx] = s_g; pb[m_widx] = d;
            m_widx = (m_widx + 1) % 256;
          end
          m_cnt = (m_cnt + 1) % 3;
        end
      endcase
    end else if (r && s == 3) begin
      if (m_cnt == 0) begin h_r = pr[m_ridx]; h_g = pg[m_ridx]; h_b = pb[m_ridx]; end
      if (m_cnt == 2) m_ridx = (m_ridx + 1) % 256;
      m_cnt = (m_cnt + 1) % 3;
    end
  endtask

  // one bus cycle: drive at negedge, compare mid-cycle, advance model at posedge
  task automatic cyc(int s, bit w, bit r, int d, int p, string tag);
    int li;
    @(negedge clk);
    sel = 2'(s); we = w; re = r; wd = 8'(d); pix = 8'(p);
    #2;
    li = p & m_mask;
    chk({tag, "/R6 lookup"}, int'(look), (pr[li] << 16) | (pg[li] << 8) | pb[li]);
    if (r && !w) chk(tag, int'(rdata), exp_rd(s));
    else         chk({tag, "/R7 idle rdata"}, int'(rdata), 0);
    @(posedge clk);
    model_step(s, w, r, d);
  endtask

  task automatic wr(int s, int d, string tag); cyc(s, 1, 0, d, 0, tag); endtask
  task automatic rd(int s, string tag);        cyc(s, 0, 1, 0, 0, tag); endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin pr[i] = 0; pg[i] = 0; pb[i] = 0; end
    m_mask = 255; m_ridx = 0; m_widx = 0; m_cnt = 0;
    h_r = 0; h_g = 0; h_b = 0; s_r = 0; s_g = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(0, "R1 mask");
    rd(1, "R1 ridx");
    rd(2, "R1 widx");
    cyc(0, 0, 0, 0, 8'hA7, "R1 pal zero");
    rd(3, "R1 data comp0");
    rd(3, "R1 hold zero");
    wr(1, 0, "R1 restore");

    // R2 readback
    wr(0, 8'h5A, "R2"); rd(0, "R2 mask");
    wr(1, 8'h33, "R2"); rd(1, "R2 ridx");
    wr(2, 8'h44, "R2"); rd(2, "R2 widx");
    wr(0, 8'hFF, "R2");

    // R3 sequential writes, R4 sequential reads
    wr(2, 8'h10, "R3");
    for (int e = 0; e < 3; e++) begin
      wr(3, 8'h11 * (e + 1), "R3");
      wr(3, 8'h21 + e, "R3");
      wr(3, 8'h31 + e, "R3");
    end
    rd(2, "R3 widx after 3");
    cyc(0, 0, 0, 0, 8'h11, "R3 entry");
    chk("R3 literal entry 0x11", int'(look), 24'h222232);
    wr(1, 8'h10, "R4");
    for (int k = 0; k < 9; k++) rd(3, "R4 data");
    rd(1, "R4 ridx after 3");
    chk("R4 literal ridx", int'(rdata), 8'h13);

    // R3/R4 wrap from 255 to 0
    wr(2, 8'hFF, "R3 wrap");
    for (int k = 0; k < 6; k++) wr(3, 8'hC0 + k, "R3 wrap");
    rd(2, "R3 widx wrap");
    wr(1, 8'hFF, "R4 wrap");
    for (int k = 0; k < 6; k++) rd(3, "R4 wrap data");
    rd(1, "R4 ridx wrap");

    // R5 pointer write abandons partial entry
    wr(2, 8'h20, "R5");
    wr(3, 8'hAA, "R5"); wr(3, 8'hBB, "R5");
    wr(2, 8'h20, "R5");
    wr(3, 8'h01, "R5"); wr(3, 8'h02, "R5"); wr(3, 8'h03, "R5");
    cyc(0, 0, 0, 0, 8'h20, "R5 entry");
    chk("R5 literal entry 0x20", int'(look), 24'h010203);
    wr(1, 8'h20, "R5"); rd(3, "R5 rd"); wr(1, 8'h11, "R5 rd abandon");
    rd(3, "R5 comp0 after ridx"); rd(3, "R5 g");

    // R7 write priority, partial entry invisible until third byte
    wr(1, 8'h40, "R7"); wr(2, 8'h40, "R7");
    cyc(3, 1, 1, 8'h77, 8'h40, "R7 both");
    cyc(3, 1, 1, 8'h88, 8'h40, "R7 both partial");
    cyc(3, 1, 1, 8'h99, 8'h40, "R7 both last");
    rd(1, "R7 ridx unchanged");
    chk("R7 literal ridx", int'(rdata), 8'h40);
    cyc(0, 0, 0, 0, 8'h40, "R7 entry");

    // R8 register reads have no effect
    for (int k = 0; k < 3; k++) rd(k % 3, "R8");
    rd(3, "R8 data after reg reads");

    // R9 shared counter
    wr(2, 8'h50, "R9"); wr(3, 8'h5E, "R9");
    rd(3, "R9 read at comp1"); rd(3, "R9 read at comp2");
    wr(3, 8'h61, "R9 next comp0");

    // R6 masked lookup
    wr(0, 8'h0F, "R6");
    cyc(0, 0, 0, 0, 8'h1F, "R6 masked");
    cyc(0, 0, 0, 0, 8'hF0, "R6 masked zero");
    wr(0, 8'h00, "R6");
    cyc(0, 0, 0, 0, 8'hFF, "R6 mask zero");
    wr(0, 8'hFF, "R6");

    // mixed random traffic
    for (int k = 0; k < 1500; k++) begin
      int s, w, r;
      s = $urandom_range(0, 9) < 6 ? 3 : $urandom_range(0, 2);
      w = $urandom_range(0, 1);
      r = $urandom_range(0, 1);
      cyc(s, w[0], r[0], $urandom_range(0, 255), $urandom_range(0, 255),
          s == 3 ? "R4/R9 rand" : "R2 rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule